// File: doc/BRIEF.md
# Four-Bit Bidirectional Universal Shift Register

This block is a small storage register with four operations. A two-bit operation select picks the operation on each rising clock edge. The register can keep its contents, shift toward its high end, shift toward its low end, or take a new four-bit word from its parallel input. Each shift direction has its own serial input. An active-low clear input empties the register at once, with no wait for a clock edge, and keeps it empty for as long as it is held low. The parallel output is the register itself and has no further stage.

The operation select is decoded into four named operations. The block has no other sequencing: the operation for each edge comes only from the select sampled at that edge.
- `OP_HOLD` (select 00): the contents stay the same.
- `OP_UP` (select 01): each bit moves one place toward the most significant bit.
- `OP_DOWN` (select 10): each bit moves one place toward the least significant bit.
- `OP_LOAD` (select 11): the whole parallel input is copied in.

Because every edge takes the operation named by that edge's select, any operation can follow any other on the next edge. Clear is not one of the four operations. It overrides all of them.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `clr_n` is 0, `par_out` is 4'b0000. The register empties as soon as `clr_n` falls, without waiting for a clock edge.
- R2: While `clr_n` is held at 0, clock edges leave the register at zero whatever the select, serial and parallel inputs are. This includes select 11.
- R3: With `clr_n` at 1 and `op_sel` = 2'b00, a rising edge leaves `par_out` unchanged. `ser_up_in`, `ser_dn_in` and `par_in` have no effect.
- R4: With `op_sel` = 2'b01, a rising edge moves bit i to bit i+1. Bit 3 drops off and `ser_up_in` enters bit 0. `ser_dn_in` and `par_in` have no effect.
- R5: With `op_sel` = 2'b10, a rising edge moves bit i+1 to bit i. Bit 0 drops off and `ser_dn_in` enters bit 3. `ser_up_in` and `par_in` have no effect.
- R6: With `op_sel` = 2'b11, a rising edge copies `par_in` into the register bit for bit. Bit 3 of `par_in` becomes bit 3 of `par_out`.
- R7: `par_out` changes only on a rising clock edge or on a fall of `clr_n`. Changing the select or data inputs between edges has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all operations |
| clr_n | input | 1 | Asynchronous clear, active low, overrides all operations |
| op_sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_up_in | input | 1 | Serial bit that enters bit 0 on an upward shift |
| ser_dn_in | input | 1 | Serial bit that enters bit 3 on a downward shift |
| par_in | input | 4 | Word copied in on a load |
| par_out | output | 4 | Current register contents |

## Verification
The register drives the output with no logic in between. A wrong next-value choice for any bit therefore shows on `par_out` right after the edge that made it, and it stays there until a load or a clear overwrites it. The stimulus table moves distinct patterns through both shift directions with the unused serial input held at the opposite value. This means a swapped serial source, a reversed shift or a misdecoded select gives a wrong word within one cycle. Clear is checked between clock edges as well as across edges, so a clear that was made synchronous would show up before the next edge.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } op_e;
endpackage

// File: rtl/usr_op_decode.sv
module usr_op_decode
    import usr_pkg::*;
(
    input  logic [1:0] op_sel,
    output op_e        op
);
    always_comb begin
        unique case (op_sel)
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_UP;
            2'b10:   op = OP_DOWN;
            2'b11:   op = OP_LOAD;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/usr_next_bit.sv
module usr_next_bit
    import usr_pkg::*;
(
    input  op_e  op,
    input  logic cur,
    input  logic from_lo,
    input  logic from_hi,
    input  logic load_bit,
    output logic nxt
);
    always_comb begin
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_UP:   nxt = from_lo;
            OP_DOWN: nxt = from_hi;
            OP_LOAD: nxt = load_bit;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_store.sv
module usr_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end

    AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!clr_n)
        !$past(clr_n) |-> (q == '0)); // R2
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       op_sel,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out
);
    localparam int MSB = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] next_q;

    usr_op_decode u_dec (
        .op_sel (op_sel),
        .op     (op)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lo_src;
        logic hi_src;
        if (i == 0) begin : g_lo_edge
            assign lo_src = ser_up_in;
        end else begin : g_lo_mid
            assign lo_src = cur_q[i-1];
        end
        if (i == MSB) begin : g_hi_edge
            assign hi_src = ser_dn_in;
        end else begin : g_hi_mid
            assign hi_src = cur_q[i+1];
        end
        usr_next_bit u_nb (
            .op       (op),
            .cur      (cur_q[i]),
            .from_lo  (lo_src),
            .from_hi  (hi_src),
            .load_bit (par_in[i]),
            .nxt      (next_q[i])
        );
    end

    usr_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (next_q),
        .q     (cur_q)
    );

    assign par_out = cur_q;

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(op_sel) == 2'b00) |-> $stable(par_out)); // R3
    AST_UP_MOVES: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(op_sel) == 2'b01)
        |-> (par_out == {$past(par_out[MSB-1:0]), $past(ser_up_in)})); // R4
    AST_DOWN_MOVES: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(op_sel) == 2'b10)
        |-> (par_out == {$past(ser_dn_in), $past(par_out[MSB:1])})); // R5
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(op_sel) == 2'b11)
        |-> (par_out == $past(par_in))); // R6
endmodule

// File: tb/tb_bidir_shift_reg.sv
module tb_bidir_shift_reg;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic       ser_up_in = 1'b0;
    logic       ser_dn_in = 1'b0;
    logic [3:0] par_in = 4'b0000;
    logic [3:0] par_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bidir_shift_reg dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .op_sel    (op_sel),
        .ser_up_in (ser_up_in),
        .ser_dn_in (ser_dn_in),
        .par_in    (par_in),
        .par_out   (par_out)
    );

    // Each entry: {op_sel, ser_up_in, ser_dn_in, par_in, expected par_out}
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        12'b11_0_0_1011_1011, // R6 load
        12'b00_0_0_0000_1011, // R3 hold, par ignored
        12'b01_0_1_0000_0110, // R4 up, 0 in
        12'b01_1_0_1111_1101, // R4 up, 1 in
        12'b10_1_0_0000_0110, // R5 down, 0 in
        12'b10_0_1_0000_1011, // R5 down, 1 in
        12'b00_1_1_1111_1011, // R3 hold, serials ignored
        12'b11_1_1_0000_0000, // R6 load zero
        12'b01_1_0_0000_0001, // R4
        12'b01_1_0_0000_0011, // R4
        12'b01_1_0_1010_0111, // R4
        12'b01_1_0_0000_1111, // R4
        12'b10_1_0_0000_0111, // R5
        12'b10_1_0_0101_0011, // R5
        12'b11_1_1_1001_1001, // R6
        12'b01_0_1_0000_0010, // R4 down serial ignored
        12'b10_1_0_0000_0001, // R5 up serial ignored
        12'b10_0_0_1111_0000  // R5
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: par_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #40000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: par_out=%b expected=completion", par_out);
        finish_up();
    end

    initial begin
        // R1: reset state
        #1;
        check("R1", par_out, 4'b0000);
        @(negedge clk);
        op_sel = 2'b11;
        par_in = 4'b1111;
        @(posedge clk); #1;
        check("R2", par_out, 4'b0000);
        @(negedge clk);
        clr_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel    = VEC[i][11:10];
            ser_up_in = VEC[i][9];
            ser_dn_in = VEC[i][8];
            par_in    = VEC[i][7:4];
            @(posedge clk); #1;
            check($sformatf("vector %0d (R3/R4/R5/R6)", i), par_out, VEC[i][3:0]);
        end

        // R7: input changes between edges do not reach the output
        @(negedge clk);
        op_sel = 2'b11;
        par_in = 4'b1111;
        @(posedge clk); #1;
        check("R6", par_out, 4'b1111);
        @(negedge clk);
        op_sel = 2'b11;
        par_in = 4'b0101;
        #1;
        check("R7", par_out, 4'b1111);
        @(posedge clk); #1;
        check("R7", par_out, 4'b0101);

        // R1: asynchronous clear between edges
        @(negedge clk);
        op_sel = 2'b00;
        #1;
        clr_n = 1'b0;
        #0.5;
        check("R1", par_out, 4'b0000);
        // R2: clear held across edges with every select
        op_sel = 2'b01; ser_up_in = 1'b1;
        @(posedge clk); #1;
        check("R2", par_out, 4'b0000);
        @(negedge clk);
        op_sel = 2'b10; ser_dn_in = 1'b1;
        @(posedge clk); #1;
        check("R2", par_out, 4'b0000);
        @(negedge clk);
        op_sel = 2'b11; par_in = 4'b1110;
        @(posedge clk); #1;
        check("R2", par_out, 4'b0000);
        @(negedge clk);
        clr_n = 1'b1;
        @(posedge clk); #1;
        check("R6", par_out, 4'b1110);

        @(negedge clk);
        finish_up();
    end
endmodule